// File: doc/BRIEF.md
# Signed Sequential Divider, Byte and Word Sizes

This block divides one two's-complement number by another. It works one quotient bit per clock, and a single engine handles two operand sizes. In byte size, a 16-bit dividend is divided by an 8-bit divisor, and the result is an 8-bit quotient and an 8-bit remainder. In word size, a 32-bit dividend is divided by a 16-bit divisor, and the result is a 16-bit quotient and a 16-bit remainder. Both results are returned packed into one word that is as wide as the dividend. The remainder goes in the upper half and the quotient in the lower half. This lets a caller write the packed word straight back over the dividend's destination.

The quotient is truncated toward zero. The remainder carries the sign of the dividend. Two cases leave the packed word equal to the original dividend and raise a flag instead:
- a divisor of zero;
- a quotient that cannot be represented in the selected signed width.

A caller pulses `start` while the block is idle and then waits for the one-cycle `done` pulse. The packed word and the two flags stay valid until the next operation is accepted. A parameter selects either the restoring or the non-restoring iteration. Both give identical results and timing.

Top module: `sdiv_dual`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `div_zero`, `overflow` and `result` are all zero.
- R2: In byte size (`size_word`=0), the result is {16 zero bits, remainder[7:0], quotient[7:0]}. The quotient is `dividend[15:0]`/`divisor[7:0]` as signed values, truncated toward zero. The remainder has the sign of the dividend.
- R3: In word size (`size_word`=1), the result is {remainder[15:0], quotient[15:0]} for the signed division `dividend[31:0]`/`divisor[15:0]`, with the same rounding and remainder sign as R2.
- R4: A start accepted while idle with a non-zero divisor raises `busy` on the next edge. `done` rises exactly N+1 edges after the accepting edge, where N is 8 in byte size and 16 in word size. `busy` stays high until that edge.
- R5: `done` lasts exactly one cycle, and `busy` is low while `done` is high.
- R6: A divisor that is zero in the selected width produces `done` on the edge after the accepting edge, with `div_zero`=1 and `overflow`=0. The result equals the dividend, and in byte size it is zero-extended from bit 15.
- R7: If the true quotient lies outside the signed range of the selected width (-128..127 or -32768..32767), `overflow`=1, `div_zero`=0, and the result equals the dividend (zero-extended in byte size). The R4 timing still applies.
- R8: A `start` pulse while `busy` is high is ignored. The operation in flight completes with its own operands.
- R9: In byte size, `dividend[31:16]` and `divisor[15:8]` have no effect on the result, the flags or the timing.
- R10: `result`, `div_zero` and `overflow` hold their values until the next accepted start. An accepted start clears both flags on its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| size_word | input | 1 | 1 = 32/16 word size, 0 = 16/8 byte size |
| dividend | input | 32 | Signed dividend (low 16 bits in byte size) |
| divisor | input | 16 | Signed divisor (low 8 bits in byte size) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | 32 | Packed {remainder, quotient} or the unchanged dividend |
| div_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation's quotient did not fit |

## Verification
The bench targets these corner cases:
- Every sign combination of dividend and divisor. A design that rounded toward minus infinity, or that gave the remainder the divisor's sign, would return the wrong packed halves for these.
- The quotient boundaries: -128 fits but +128 does not, -32768 fits but +32768 does not, and the most negative dividend divided by -1. A design with an off-by-one range check would either miss the overflow flag or wrongly raise it.
- Byte-size operations with garbage in the unused upper operand bits, which catch a design that sign-extends from the wrong bit.
- A start pulse in the middle of an operation, which would corrupt a design that reloads its operands.
- Zero divisors in both sizes, where a design must answer after one cycle without touching the dividend.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } sdiv_state_e;

   // magnitude of a two's-complement value held in W bits
   function automatic logic [63:0] mag64(input logic [63:0] v, input logic neg);
      return neg ? (~v + 64'd1) : v;
   endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
   parameter int DW = 16
) (
   input  logic              size_word,
   input  logic [2*DW-1:0]   dividend,
   input  logic [DW-1:0]     divisor,
   output logic [DW:0]       prem_init,
   output logic [DW-1:0]     lo_init,
   output logic [DW-1:0]     d_mag,
   output logic              neg_q,
   output logic              neg_r,
   output logic              zero_div,
   output logic              early_ovf,
   output logic [2*DW-1:0]   keep
);
   localparam int HW = DW / 2;

   logic [2*DW-1:0] dvd_ext;
   logic [DW-1:0]   dvs_ext;
   logic [2*DW-1:0] dvd_mag;
   logic [DW-1:0]   p_hi;

   always_comb begin
      if (size_word) begin
         dvd_ext = dividend;
         dvs_ext = divisor;
         keep    = dividend;
      end else begin
         dvd_ext = {{DW{dividend[DW-1]}}, dividend[DW-1:0]};
         dvs_ext = {{HW{divisor[HW-1]}}, divisor[HW-1:0]};
         keep    = {{DW{1'b0}}, dividend[DW-1:0]};
      end
      neg_r    = dvd_ext[2*DW-1];
      neg_q    = dvd_ext[2*DW-1] ^ dvs_ext[DW-1];
      dvd_mag  = dvd_ext[2*DW-1] ? (~dvd_ext + 1'b1) : dvd_ext;
      d_mag    = dvs_ext[DW-1] ? (~dvs_ext + 1'b1) : dvs_ext;
      zero_div = (dvs_ext == '0);
      if (size_word) begin
         p_hi    = dvd_mag[2*DW-1:DW];
         lo_init = dvd_mag[DW-1:0];
      end else begin
         p_hi    = {{HW{1'b0}}, dvd_mag[DW-1:HW]};
         lo_init = {dvd_mag[HW-1:0], {HW{1'b0}}};
      end
      prem_init = {1'b0, p_hi};
      // quotient magnitude would need more than N bits
      early_ovf = (p_hi >= d_mag);
   end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
   parameter int DW          = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic [DW:0]   prem,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] d,
   output logic [DW:0]   prem_nx,
   output logic [DW-1:0] lo_nx
);
   logic [DW+1:0] shifted;
   logic [DW+1:0] dext;
   logic [DW+1:0] trial;
   logic          qbit;

   assign shifted = {prem, lo[DW-1]};
   assign dext    = {2'b00, d};

   generate
      if (NONRESTORING) begin : g_nonrestoring
         // partial remainder is signed; add back when negative
         always_comb begin
            trial   = prem[DW] ? (shifted + dext) : (shifted - dext);
            qbit    = ~trial[DW+1];
            prem_nx = trial[DW:0];
         end
      end else begin : g_restoring
         always_comb begin
            trial   = shifted - dext;
            qbit    = ~trial[DW+1];
            prem_nx = qbit ? trial[DW:0] : shifted[DW:0];
         end
      end
   endgenerate

   assign lo_nx = {lo[DW-2:0], qbit};
endmodule

// File: rtl/sdiv_pack.sv
module sdiv_pack #(
   parameter int DW           = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic              size_word,
   input  logic [DW:0]       prem,
   input  logic [DW-1:0]     lo,
   input  logic [DW-1:0]     d,
   input  logic              neg_q,
   input  logic              neg_r,
   input  logic              early_ovf,
   input  logic [2*DW-1:0]   keep,
   output logic [2*DW-1:0]   result,
   output logic              ovf
);
   localparam int HW = DW / 2;
   localparam logic [DW:0] WORD_LIM = (DW+1)'((1 << (DW-1)) - 1);
   localparam logic [DW:0] BYTE_LIM = (DW+1)'((1 << (HW-1)) - 1);

   logic [DW-1:0] r_mag;
   logic [DW-1:0] q_mag;
   logic [DW:0]   lim;
   logic [DW-1:0] q_s;
   logic [DW-1:0] r_s;
   logic          late_ovf;

   generate
      if (NONRESTORING) begin : g_fix_nr
         logic [DW:0] corr;
         assign corr  = prem[DW] ? (prem + {1'b0, d}) : prem;
         assign r_mag = corr[DW-1:0];
      end else begin : g_fix_r
         assign r_mag = prem[DW-1:0];
      end
   endgenerate

   always_comb begin
      q_mag    = size_word ? lo : {{HW{1'b0}}, lo[HW-1:0]};
      lim      = (size_word ? WORD_LIM : BYTE_LIM) + {{DW{1'b0}}, neg_q};
      late_ovf = ({1'b0, q_mag} > lim);
      q_s      = neg_q ? (~q_mag + 1'b1) : q_mag;
      r_s      = neg_r ? (~r_mag + 1'b1) : r_mag;
      ovf      = early_ovf | late_ovf;
      if (ovf)
         result = keep;
      else if (size_word)
         result = {r_s, q_s};
      else
         result = {{DW{1'b0}}, r_s[HW-1:0], q_s[HW-1:0]};
   end
endmodule

// File: rtl/sdiv_dual.sv
module sdiv_dual #(
   parameter int DW           = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              size_word,
   input  logic [2*DW-1:0]   dividend,
   input  logic [DW-1:0]     divisor,
   output logic              busy,
   output logic              done,
   output logic [2*DW-1:0]   result,
   output logic              div_zero,
   output logic              overflow
);
   import sdiv_pkg::*;

   localparam int HW = DW / 2;
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] N_WORD = CW'(DW);
   localparam logic [CW-1:0] N_BYTE = CW'(HW);

   generate
      if (DW < 4 || (DW % 2) != 0) begin : g_bad_width
         $error("sdiv_dual: DW must be even and at least 4");
      end
   endgenerate

   sdiv_state_e         state;
   logic [CW-1:0]       cnt;
   logic [DW:0]         prem;
   logic [DW-1:0]       lo;
   logic [DW-1:0]       d_r;
   logic                neg_q_r, neg_r_r, eovf_r, size_r;
   logic [2*DW-1:0]     keep_r;

   logic [DW:0]         pi_prem;
   logic [DW-1:0]       pi_lo, pi_d;
   logic                pi_nq, pi_nr, pi_zero, pi_eovf;
   logic [2*DW-1:0]     pi_keep;
   logic [DW:0]         st_prem;
   logic [DW-1:0]       st_lo;
   logic [2*DW-1:0]     pk_result;
   logic                pk_ovf;
   logic                accept;

   sdiv_prep #(.DW(DW)) u_prep (
      .size_word (size_word),
      .dividend  (dividend),
      .divisor   (divisor),
      .prem_init (pi_prem),
      .lo_init   (pi_lo),
      .d_mag     (pi_d),
      .neg_q     (pi_nq),
      .neg_r     (pi_nr),
      .zero_div  (pi_zero),
      .early_ovf (pi_eovf),
      .keep      (pi_keep)
   );

   sdiv_step #(.DW(DW), .NONRESTORING(NONRESTORING)) u_step (
      .prem    (prem),
      .lo      (lo),
      .d       (d_r),
      .prem_nx (st_prem),
      .lo_nx   (st_lo)
   );

   sdiv_pack #(.DW(DW), .NONRESTORING(NONRESTORING)) u_pack (
      .size_word (size_r),
      .prem      (prem),
      .lo        (lo),
      .d         (d_r),
      .neg_q     (neg_q_r),
      .neg_r     (neg_r_r),
      .early_ovf (eovf_r),
      .keep      (keep_r),
      .result    (pk_result),
      .ovf       (pk_ovf)
   );

   assign accept = start && (state == ST_IDLE);
   assign busy   = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         prem     <= '0;
         lo       <= '0;
         d_r      <= '0;
         neg_q_r  <= 1'b0;
         neg_r_r  <= 1'b0;
         eovf_r   <= 1'b0;
         size_r   <= 1'b0;
         keep_r   <= '0;
         result   <= '0;
         done     <= 1'b0;
         div_zero <= 1'b0;
         overflow <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  overflow <= 1'b0;
                  if (pi_zero) begin
                     div_zero <= 1'b1;
                     result   <= pi_keep;
                     done     <= 1'b1;
                  end else begin
                     div_zero <= 1'b0;
                     state    <= ST_RUN;
                     cnt      <= size_word ? N_WORD : N_BYTE;
                     prem     <= pi_prem;
                     lo       <= pi_lo;
                     d_r      <= pi_d;
                     neg_q_r  <= pi_nq;
                     neg_r_r  <= pi_nr;
                     eovf_r   <= pi_eovf;
                     size_r   <= size_word;
                     keep_r   <= pi_keep;
                  end
               end
            end
            ST_RUN: begin
               prem <= st_prem;
               lo   <= st_lo;
               cnt  <= cnt - 1'b1;
               if (cnt == CW'(1))
                  state <= ST_FIX;
            end
            ST_FIX: begin
               result   <= pk_result;
               overflow <= pk_ovf;
               done     <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R5
   AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy || done)); // R4
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(div_zero && overflow)); // R7
   AST_ZERO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_zero) |-> done); // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done); // R10
   AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !eovf_r) |->
         (($signed(prem) < $signed({1'b0, d_r})) &&
          ($signed(prem) >= -$signed({1'b0, d_r})))); // R3

endmodule

// File: tb/sdiv_dual_test.sv
module sdiv_dual_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        size_word = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, done, div_zero, overflow;
   logic [31:0] result;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit chk_en = 1'b0;
   string cur_tag = "R2";

   // reference model state
   bit          m_busy = 0, m_done = 0, m_dz = 0, m_ov = 0;
   logic [31:0] m_res = '0, p_res = '0;
   bit          p_ov = 0;
   int          m_cnt = 0;
   string       m_tag = "R1", p_tag = "R1";

   always #2.5 clk = ~clk;

   sdiv_dual uut (
      .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word),
      .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
      .result(result), .div_zero(div_zero), .overflow(overflow)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         m_done = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1; m_res = p_res; m_ov = p_ov; m_tag = p_tag;
            end
         end else if (start) begin
            longint a, b, q, r, lim;
            logic [31:0] keep;
            m_dz = 0; m_ov = 0;
            if (size_word) begin
               a = longint'($signed(dividend)); b = longint'($signed(divisor));
               lim = 32768; keep = dividend;
            end else begin
               a = longint'($signed(dividend[15:0])); b = longint'($signed(divisor[7:0]));
               lim = 128; keep = {16'h0, dividend[15:0]};
            end
            if (b == 0) begin
               m_done = 1; m_dz = 1; m_res = keep; m_tag = "R6";
            end else begin
               q = a / b; r = a % b;
               p_tag = cur_tag;
               p_ov  = (q >= lim) || (q < -lim);
               if (p_ov) p_res = keep;
               else if (size_word) p_res = {r[15:0], q[15:0]};
               else p_res = {16'h0, r[7:0], q[7:0]};
               m_busy = 1; m_cnt = size_word ? 17 : 9;
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && chk_en) begin
         check(busy === m_busy, "R4", "busy", longint'(busy), longint'(m_busy));
         check(done === m_done, "R5", "done", longint'(done), longint'(m_done));
         check(result === m_res, m_tag, "result", longint'(result), longint'(m_res));
         check(div_zero === m_dz, "R6", "div_zero", longint'(div_zero), longint'(m_dz));
         check(overflow === m_ov, "R7", "overflow", longint'(overflow), longint'(m_ov));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 60000) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic run_op(input bit w, input logic [31:0] a, input logic [15:0] b,
                         input string tag);
      @(negedge clk);
      cur_tag = tag; size_word = w; dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 40 && !done; i++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy === 0 && done === 0 && result === 0 && div_zero === 0 && overflow === 0,
            "R1", "reset outputs", longint'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 0 && done === 0 && result === 0, "R1", "after reset",
            longint'(result), 0);
      chk_en = 1'b1;

      // R2 byte size, all sign combinations and boundaries
      run_op(0, 32'd100, 16'd7, "R2");
      run_op(0, 32'hFF9C, 16'd7, "R2");
      run_op(0, 32'd100, 16'hF9, "R2");
      run_op(0, 32'hFF9C, 16'hF9, "R2");
      run_op(0, 32'hFF00, 16'd2, "R2");      // -256/2 = -128 fits
      run_op(0, 32'd5, 16'd9, "R2");
      // R3 word size
      run_op(1, 32'd1000000, 16'hFED4, "R3");
      run_op(1, 32'hC0000000, 16'h8000, "R3"); // -2^30 / -32768 = 32768 -> ovf
      run_op(1, 32'hC0000000, 16'd32767, "R3");
      run_op(1, -32'sd7, 16'd2, "R3");
      run_op(1, 32'hFFFF8000, 16'd1, "R3");  // -32768 fits
      // R7 overflow cases
      run_op(0, 32'd256, 16'd2, "R7");
      run_op(0, 32'h8000, 16'hFF, "R7");
      run_op(1, 32'h80000000, 16'hFFFF, "R7");
      run_op(1, 32'd32768, 16'd1, "R7");
      // R10 flags clear on next accept
      @(negedge clk);
      size_word = 0; dividend = 32'd9; divisor = 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(overflow === 0, "R10", "flag cleared at accept", longint'(overflow), 0);
      for (int i = 0; i < 40 && !done; i++) @(negedge clk);
      // R6 zero divisor both sizes
      run_op(0, 32'h1234ABCD, 16'hAB00, "R6");
      run_op(1, 32'h89ABCDEF, 16'h0000, "R6");
      // R9 byte size ignores upper operand bits
      run_op(0, 32'hDEAD0064, 16'h5507, "R9");
      run_op(0, 32'h0000FF9C, 16'hFFF9, "R9");
      // R8 start during busy is ignored
      @(negedge clk);
      cur_tag = "R8"; size_word = 1; dividend = 32'd123456; divisor = 16'd100; start = 1;
      @(negedge clk);
      start = 0;
      repeat (3) @(negedge clk);
      dividend = 32'd7; divisor = 16'd0; size_word = 0; start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 40 && !done; i++) @(negedge clk);
      // R10 hold while idle
      repeat (10) @(negedge clk);
      check(result === m_res && done === 0, "R10", "held result",
            longint'(result), longint'(m_res));
      // random mixed traffic
      for (int k = 0; k < 60; k++) begin
         logic [31:0] a;
         logic [15:0] b;
         a = $urandom;
         b = $urandom;
         if (k % 3 == 0) a = a >>> (k % 20);
         if (k % 7 == 0) b = 16'd0;
         run_op(k[0], a, b, k[0] ? "R3" : "R2");
      end
      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule